// File: doc/BRIEF.md
# Byte-wide one-time-programmable memory programming sequencer

This block sits on the host side of a byte-wide one-time-programmable memory and writes a contiguous address range into it. A single start command supplies the first and last address. The block fetches each source byte from a buffer by address, and drives the memory's address, data, chip-enable, output-enable and program-strobe lines. It also raises digital request lines that an external regulator turns into the programming and boosted supply rails. An erased byte reads as all ones, and a pulse can only clear bits.

For every address the sequencer applies a program pulse and then reads the byte back. It pulses again only while the byte still differs, up to a parameterised pulse limit. A byte that would need a cleared bit set again cannot be fixed, so it is rejected at its first mismatching read-back. After the last address, the sequencer drops the programming and boost requests and asserts the verify-level request. It then reads the whole range once more against the source. Every interval is counted in clock cycles, derived from nanosecond parameters and the clock frequency. The block finishes with done, a fail flag and the failing address.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset and while idle: chip-enable, output-enable and program strobe are high (inactive) and the host does not drive data. All three rail requests, busy, done and fail are low.
- R2: The program strobe is low only while chip-enable is low, output-enable is high, the host drives the data bus, and both the programming-rail and boost requests are high.
- R3: Each program pulse is exactly ceil(PULSE_NS*CLK_MHZ/1000) cycles long. Before each pulse, address and data are driven unchanged with output-enable high for at least the setup count of cycles. After each pulse, they stay driven unchanged for at least the hold count.
- R4: After every pulse the byte is read back with chip-enable and output-enable low, the strobe high, the host data driver off and the programming-rail request still high. The read-back is sampled only after output-enable has been low for the read count of cycles.
- R5: An address receives pulses until its read-back equals the source byte, with at least one pulse, and then no further pulses. Afterwards the memory holds the source bytes over the whole range.
- R6: If the read-back still mismatches after MAX_PULSES pulses, the sequencer stops without pulsing any later address. It raises fail and done and reports that address.
- R7: A source byte that has a 1 where the read-back has a 0 fails at the first mismatching read-back, after exactly one pulse at that address.
- R8: After the last address is programmed, the programming-rail and boost requests fall and the verify-level request rises. Each address from first to last is read again and compared with the source byte. A mismatch raises fail and done with that address. No final read happens after a failure in the pulse loop.
- R9: On success, done is high, fail and busy are low and all rail requests are low. Done, fail and the failing address hold until the next accepted start. A start while busy is ignored.
- R10: A range whose first and last address are equal programs and verifies only that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, sampled when not busy |
| first_addr_i | input | AW | First address of the range |
| last_addr_i | input | AW | Last address of the range |
| src_addr_o | output | AW | Address into the source buffer |
| src_data_i | input | 8 | Source byte at src_addr_o (combinational read) |
| mem_addr_o | output | AW | Memory address lines |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Host data driver enable |
| mem_dq_i | input | 8 | Data read from the memory |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_pgm_n_o | output | 1 | Program strobe, active low |
| vpp_pgm_o | output | 1 | Request programming-level rail |
| vcc_boost_o | output | 1 | Request boosted supply for the pulse loop |
| vfy_rails_o | output | 1 | Request verify-level rails for the final pass |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |
| fail_o | output | 1 | Sequence finished with a failure |
| fail_addr_o | output | AW | Address that failed |

## Verification
The bench models the memory with a per-address count of pulses needed before the bits take. Its data is reported as wrong until output-enable has been low for the read window. So a sequencer that samples one cycle early, stops after the first pulse, or keeps pulsing after a match produces a wrong byte or a wrong pulse count. Other scenarios target the failure paths. One cell never takes, and a design that ignored the limit would pulse it forever. One byte asks for a cleared bit back, and a design missing that check would burn all retries. One cell reads wrong only under verify rails, and a design that skipped the final pass would report success. Pulse width, setup and hold windows, the rail state during pulses and reads, and bus contention are measured at every edge, along with a start pulse issued mid-run.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_LOAD  = 4'd1,
    ST_SETUP = 4'd2,
    ST_PULSE = 4'd3,
    ST_HOLD  = 4'd4,
    ST_VREAD = 4'd5,
    ST_FLOAT = 4'd6,
    ST_VSET  = 4'd7,
    ST_VCHK  = 4'd8,
    ST_DONE  = 4'd9
  } seq_state_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/otp_prog_timer.sv
module otp_prog_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : (cnt_q - TW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R3: a running window shortens by exactly one cycle per clock
  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TW'(1)));

endmodule

// File: rtl/otp_prog_cmp.sv
module otp_prog_cmp #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] ref_i,
  input  logic [DW-1:0] rd_i,
  output logic          mismatch_o,
  output logic          illegal_o
);

  logic [DW-1:0] diff;
  logic [DW-1:0] set_back;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign diff[b]     = ref_i[b] ^ rd_i[b];
    assign set_back[b] = ref_i[b] & ~rd_i[b];
  end

  assign mismatch_o = |diff;
  assign illegal_o  = |set_back;

  // R7: a bit that wants to return to one is always also a mismatch
  always_comb begin
    p_illegal_is_mismatch_r7: assert (!(illegal_o && !mismatch_o));
  end

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
#(
  parameter int unsigned AW         = 4,
  parameter int unsigned DW         = 8,
  parameter int unsigned TW         = 8,
  parameter int unsigned PCW        = 3,
  parameter int unsigned MAX_PULSES = 4,
  parameter int unsigned SU_C       = 2,
  parameter int unsigned PW_C       = 4,
  parameter int unsigned HD_C       = 2,
  parameter int unsigned RD_C       = 2,
  parameter int unsigned FL_C       = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] first_i,
  input  logic [AW-1:0] last_i,
  input  logic [DW-1:0] src_data_i,
  input  logic          mismatch_i,
  input  logic          illegal_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic [DW-1:0] ref_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          ce_n_o,
  output logic          oe_n_o,
  output logic          pgm_n_o,
  output logic          vpp_pgm_o,
  output logic          vcc_boost_o,
  output logic          vfy_rails_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o
);

  localparam logic [TW-1:0]  SU_V  = TW'(SU_C - 1);
  localparam logic [TW-1:0]  PW_V  = TW'(PW_C - 1);
  localparam logic [TW-1:0]  HD_V  = TW'(HD_C - 1);
  localparam logic [TW-1:0]  RD_V  = TW'(RD_C - 1);
  localparam logic [TW-1:0]  FL_V  = TW'(FL_C - 1);
  localparam logic [PCW-1:0] P_MAX = PCW'(MAX_PULSES);

  seq_state_e     state_q, state_d;
  logic [AW-1:0]  cur_q, cur_d;
  logic [AW-1:0]  first_q, last_q;
  logic [DW-1:0]  target_q;
  logic [PCW-1:0] pulses_q, pulses_d;
  logic           adv_q, adv_d;
  logic [AW-1:0]  fail_addr_q, fail_addr_d;
  logic           done_q, done_d, fail_q, fail_d;
  logic           range_en, target_en;
  logic           at_last;

  logic dq_oe_q, ce_n_q, oe_n_q, pgm_n_q, vpp_q, boost_q, vfy_q, busy_q;
  logic dq_oe_d, ce_n_d, oe_n_d, pgm_n_d, vpp_d, boost_d, vfy_d, busy_d;

  assign at_last = (cur_q == last_q);
  assign ref_o   = (state_q == ST_VCHK) ? src_data_i : target_q;

  // next-state logic
  always_comb begin
    state_d     = state_q;
    cur_d       = cur_q;
    pulses_d    = pulses_q;
    adv_d       = adv_q;
    fail_addr_d = fail_addr_q;
    done_d      = done_q;
    fail_d      = fail_q;
    range_en    = 1'b0;
    target_en   = 1'b0;
    tmr_load_o  = 1'b0;
    tmr_val_o   = '0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          range_en    = 1'b1;
          cur_d       = first_i;
          done_d      = 1'b0;
          fail_d      = 1'b0;
          fail_addr_d = '0;
          state_d     = ST_LOAD;
        end
      end
      ST_LOAD: begin
        target_en  = 1'b1;
        pulses_d   = '0;
        tmr_load_o = 1'b1;
        tmr_val_o  = SU_V;
        state_d    = ST_SETUP;
      end
      ST_SETUP: begin
        if (tmr_zero_i) begin
          pulses_d   = pulses_q + PCW'(1);
          tmr_load_o = 1'b1;
          tmr_val_o  = PW_V;
          state_d    = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (tmr_zero_i) begin
          tmr_load_o = 1'b1;
          tmr_val_o  = HD_V;
          state_d    = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tmr_zero_i) begin
          tmr_load_o = 1'b1;
          tmr_val_o  = RD_V;
          state_d    = ST_VREAD;
        end
      end
      ST_VREAD: begin
        if (tmr_zero_i) begin
          if (!mismatch_i) begin
            adv_d      = 1'b1;
            tmr_load_o = 1'b1;
            tmr_val_o  = FL_V;
            state_d    = ST_FLOAT;
          end else if (illegal_i || (pulses_q >= P_MAX)) begin
            fail_d      = 1'b1;
            done_d      = 1'b1;
            fail_addr_d = cur_q;
            state_d     = ST_DONE;
          end else begin
            adv_d      = 1'b0;
            tmr_load_o = 1'b1;
            tmr_val_o  = FL_V;
            state_d    = ST_FLOAT;
          end
        end
      end
      ST_FLOAT: begin
        if (tmr_zero_i) begin
          if (!adv_q) begin
            tmr_load_o = 1'b1;
            tmr_val_o  = SU_V;
            state_d    = ST_SETUP;
          end else if (at_last) begin
            tmr_load_o = 1'b1;
            tmr_val_o  = SU_V;
            state_d    = ST_VSET;
          end else begin
            cur_d   = cur_q + AW'(1);
            state_d = ST_LOAD;
          end
        end
      end
      ST_VSET: begin
        if (tmr_zero_i) begin
          cur_d      = first_q;
          tmr_load_o = 1'b1;
          tmr_val_o  = RD_V;
          state_d    = ST_VCHK;
        end
      end
      ST_VCHK: begin
        if (tmr_zero_i) begin
          if (mismatch_i) begin
            fail_d      = 1'b1;
            done_d      = 1'b1;
            fail_addr_d = cur_q;
            state_d     = ST_DONE;
          end else if (at_last) begin
            done_d  = 1'b1;
            state_d = ST_DONE;
          end else begin
            cur_d      = cur_q + AW'(1);
            tmr_load_o = 1'b1;
            tmr_val_o  = RD_V;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // pin levels follow the state being entered, so they switch with it
  always_comb begin
    ce_n_d  = 1'b1;
    oe_n_d  = 1'b1;
    pgm_n_d = 1'b1;
    dq_oe_d = 1'b0;
    vpp_d   = 1'b0;
    boost_d = 1'b0;
    vfy_d   = 1'b0;
    busy_d  = 1'b1;
    unique case (state_d)
      ST_IDLE, ST_DONE: busy_d = 1'b0;
      ST_LOAD, ST_FLOAT: begin
        ce_n_d = 1'b0; vpp_d = 1'b1; boost_d = 1'b1;
      end
      ST_SETUP, ST_HOLD: begin
        ce_n_d = 1'b0; vpp_d = 1'b1; boost_d = 1'b1; dq_oe_d = 1'b1;
      end
      ST_PULSE: begin
        ce_n_d = 1'b0; vpp_d = 1'b1; boost_d = 1'b1; dq_oe_d = 1'b1;
        pgm_n_d = 1'b0;
      end
      ST_VREAD: begin
        ce_n_d = 1'b0; vpp_d = 1'b1; boost_d = 1'b1; oe_n_d = 1'b0;
      end
      ST_VSET: begin
        ce_n_d = 1'b0; vfy_d = 1'b1;
      end
      ST_VCHK: begin
        ce_n_d = 1'b0; vfy_d = 1'b1; oe_n_d = 1'b0;
      end
      default: busy_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      pulses_q    <= '0;
      adv_q       <= 1'b0;
      fail_addr_q <= '0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
      ce_n_q      <= 1'b1;
      oe_n_q      <= 1'b1;
      pgm_n_q     <= 1'b1;
      dq_oe_q     <= 1'b0;
      vpp_q       <= 1'b0;
      boost_q     <= 1'b0;
      vfy_q       <= 1'b0;
      busy_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      cur_q       <= cur_d;
      pulses_q    <= pulses_d;
      adv_q       <= adv_d;
      fail_addr_q <= fail_addr_d;
      done_q      <= done_d;
      fail_q      <= fail_d;
      ce_n_q      <= ce_n_d;
      oe_n_q      <= oe_n_d;
      pgm_n_q     <= pgm_n_d;
      dq_oe_q     <= dq_oe_d;
      vpp_q       <= vpp_d;
      boost_q     <= boost_d;
      vfy_q       <= vfy_d;
      busy_q      <= busy_d;
    end
  end

  // data-path registers: clock enables only, no reset needed
  always_ff @(posedge clk_i) begin
    if (range_en) begin
      first_q <= first_i;
      last_q  <= last_i;
    end
    if (target_en) begin
      target_q <= src_data_i;
    end
  end

  assign cur_addr_o  = cur_q;
  assign dq_o        = target_q;
  assign dq_oe_o     = dq_oe_q;
  assign ce_n_o      = ce_n_q;
  assign oe_n_o      = oe_n_q;
  assign pgm_n_o     = pgm_n_q;
  assign vpp_pgm_o   = vpp_q;
  assign vcc_boost_o = boost_q;
  assign vfy_rails_o = vfy_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign fail_addr_o = fail_addr_q;

  // R2: strobe only in full programming context
  p_pulse_ctx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pgm_n_q |-> (!ce_n_q && oe_n_q && dq_oe_q && vpp_q && boost_q));

  // R4: loop read-back never overlaps the strobe or the host driver
  p_read_ctx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_n_q && vpp_q) |-> (pgm_n_q && !dq_oe_q && !ce_n_q));

  // R6: pulse count never passes the limit
  p_pulse_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulses_q <= P_MAX);

  // R8: verify-level rails exclude the programming requests
  p_final_rails_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vfy_q |-> (!vpp_q && !boost_q && pgm_n_q));

  // R9: failure report holds until a new start
  p_fail_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !start_i) |=> (fail_q && $stable(fail_addr_q)));

  // R1: idle leaves the memory deselected with rails off
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (ce_n_q && oe_n_q && pgm_n_q && !dq_oe_q && !vpp_q && !vfy_q));

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_prog_pkg::*;
#(
  parameter int unsigned AW         = 18,
  parameter int unsigned MAX_PULSES = 25,
  parameter int unsigned CLK_MHZ    = 250,
  parameter int unsigned PULSE_NS   = 75000,
  parameter int unsigned SETUP_NS   = 2000,
  parameter int unsigned HOLD_NS    = 2000,
  parameter int unsigned READ_NS    = 150,
  parameter int unsigned FLOAT_NS   = 130
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     first_addr_i,
  input  logic [AW-1:0]     last_addr_i,
  output logic [AW-1:0]     src_addr_o,
  input  logic [BYTE_W-1:0] src_data_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BYTE_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [BYTE_W-1:0] mem_dq_i,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_pgm_n_o,
  output logic              vpp_pgm_o,
  output logic              vcc_boost_o,
  output logic              vfy_rails_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [AW-1:0]     fail_addr_o
);

  function automatic int unsigned ns2cyc(input int unsigned ns);
    int unsigned c;
    c = (ns * CLK_MHZ + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned SU_C  = ns2cyc(SETUP_NS);
  localparam int unsigned PW_C  = ns2cyc(PULSE_NS);
  localparam int unsigned HD_C  = ns2cyc(HOLD_NS);
  localparam int unsigned RD_C  = ns2cyc(READ_NS);
  localparam int unsigned FL_C  = ns2cyc(FLOAT_NS);
  localparam int unsigned MAX_C = max2(max2(max2(SU_C, PW_C), max2(HD_C, RD_C)), FL_C);
  localparam int unsigned TW    = $clog2(MAX_C + 1);
  localparam int unsigned PCW   = $clog2(MAX_PULSES + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic [BYTE_W-1:0] cmp_ref;
  logic              mismatch, illegal;
  logic [AW-1:0]     cur_addr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  otp_prog_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  otp_prog_cmp #(.DW(BYTE_W)) u_cmp (
    .ref_i      (cmp_ref),
    .rd_i       (mem_dq_i),
    .mismatch_o (mismatch),
    .illegal_o  (illegal)
  );

  otp_prog_ctrl #(
    .AW(AW), .DW(BYTE_W), .TW(TW), .PCW(PCW), .MAX_PULSES(MAX_PULSES),
    .SU_C(SU_C), .PW_C(PW_C), .HD_C(HD_C), .RD_C(RD_C), .FL_C(FL_C)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .start_i     (start_i),
    .first_i     (first_addr_i),
    .last_i      (last_addr_i),
    .src_data_i  (src_data_i),
    .mismatch_i  (mismatch),
    .illegal_i   (illegal),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .ref_o       (cmp_ref),
    .cur_addr_o  (cur_addr),
    .dq_o        (mem_dq_o),
    .dq_oe_o     (mem_dq_oe_o),
    .ce_n_o      (mem_ce_n_o),
    .oe_n_o      (mem_oe_n_o),
    .pgm_n_o     (mem_pgm_n_o),
    .vpp_pgm_o   (vpp_pgm_o),
    .vcc_boost_o (vcc_boost_o),
    .vfy_rails_o (vfy_rails_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o)
  );

  assign src_addr_o = cur_addr;
  assign mem_addr_o = cur_addr;

endmodule

// File: tb/otp_prog_seq_tb_top.sv
`timescale 1ns/1ps
module otp_prog_seq_tb_top;

  localparam int AW   = 4;
  localparam int N    = 16;
  localparam int MAXP = 4;
  localparam int PWC  = (40 * 250 + 999) / 1000;
  localparam int SUC  = (20 * 250 + 999) / 1000;
  localparam int HDC  = (12 * 250 + 999) / 1000;
  localparam int RDC  = (16 * 250 + 999) / 1000;

  logic clk, rst_n, start;
  logic [AW-1:0] first_a, last_a, src_addr, mem_addr, fail_addr;
  logic [7:0] src_data, dq_o, dq_i;
  logic dq_oe, ce_n, oe_n, pgm_n, vpp, boost, vfy, busy, done, fail;

  logic [7:0] src_mem [N];
  logic [7:0] mem [N];
  int need [N];
  int pcount [N];
  logic [N-1:0] final_seen;
  int rd_cnt;
  logic [AW-1:0] prev_addr;
  logic weak_en;
  logic [AW-1:0] weak_a;

  int checks = 0, failures = 0, cyc = 0;
  int pw_run, su_run, hold_run, pw_err, su_err, hd_err, rail_err, rd_err, cont_err;
  logic in_hold;
  logic [7:0] hd_data, su_data;
  logic [AW-1:0] hd_addr, su_addr;

  otp_prog_seq #(
    .AW(AW), .MAX_PULSES(MAXP), .CLK_MHZ(250), .PULSE_NS(40), .SETUP_NS(20),
    .HOLD_NS(12), .READ_NS(16), .FLOAT_NS(12)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .first_addr_i(first_a), .last_addr_i(last_a),
    .src_addr_o(src_addr), .src_data_i(src_data),
    .mem_addr_o(mem_addr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i),
    .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_pgm_n_o(pgm_n),
    .vpp_pgm_o(vpp), .vcc_boost_o(boost), .vfy_rails_o(vfy),
    .busy_o(busy), .done_o(done), .fail_o(fail), .fail_addr_o(fail_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign src_data = src_mem[src_addr];
  assign dq_i = (!ce_n && !oe_n && rd_cnt >= RDC - 1)
              ? (mem[mem_addr] ^ ((vfy && weak_en && mem_addr == weak_a) ? 8'h01 : 8'h00))
              : ~mem[mem_addr];

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  // memory model and interface monitors
  always @(posedge clk) begin
    if (rst_n) begin
      // pulse start: setup window (R3)
      if (!pgm_n && pw_run == 0 && su_run < SUC) su_err = su_err + 1;
      if (!pgm_n) begin
        if (!(!ce_n && oe_n && dq_oe && vpp && boost)) rail_err = rail_err + 1;
        pw_run = pw_run + 1;
      end else if (pw_run != 0) begin
        if (pw_run != PWC) pw_err = pw_err + 1;
        pw_run = 0;
        pcount[mem_addr] = pcount[mem_addr] + 1;
        if (pcount[mem_addr] >= need[mem_addr]) mem[mem_addr] <= mem[mem_addr] & dq_o;
        in_hold = 1'b1; hold_run = 1; hd_data = dq_o; hd_addr = mem_addr;
      end else if (in_hold) begin
        if (dq_oe && dq_o == hd_data && mem_addr == hd_addr) hold_run = hold_run + 1;
        else begin
          if (hold_run < HDC) hd_err = hd_err + 1;
          in_hold = 1'b0;
        end
      end
      // setup run length
      if (!(pgm_n && dq_oe && !ce_n && oe_n)) su_run = 0;
      else if (su_run != 0 && (dq_o != su_data || mem_addr != su_addr)) su_run = 1;
      else su_run = su_run + 1;
      su_data = dq_o; su_addr = mem_addr;
      // reads (R4, R8)
      if (!ce_n && !oe_n) begin
        if (dq_oe) cont_err = cont_err + 1;
        if (vpp) begin
          if (!pgm_n) rd_err = rd_err + 1;
        end else if (vfy) begin
          if (boost) rd_err = rd_err + 1;
          final_seen[mem_addr] = 1'b1;
        end else rd_err = rd_err + 1;
      end
      if (ce_n || oe_n) rd_cnt <= 0;
      else if (mem_addr != prev_addr) rd_cnt <= 1;
      else rd_cnt <= rd_cnt + 1;
      prev_addr <= mem_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fresh();
    for (int a = 0; a < N; a++) begin
      mem[a] = 8'hFF; pcount[a] = 0; need[a] = (a % 3) + 1;
      src_mem[a] = 8'((a * 37 + 11) & 8'hFF);
    end
    final_seen = '0; weak_en = 1'b0; weak_a = '0;
    pw_run = 0; su_run = 0; hold_run = 0; in_hold = 1'b0;
    pw_err = 0; su_err = 0; hd_err = 0; rail_err = 0; rd_err = 0; cont_err = 0;
  endtask

  task automatic kick(input int lo, input int hi);
    @(negedge clk);
    first_a = AW'(lo); last_a = AW'(hi); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  function automatic int exp_pulses(input int a);
    return (src_mem[a] == 8'hFF) ? 1 : need[a];
  endfunction

  task automatic timing_checks(input string tag);
    chk(pw_err == 0, {tag, " R3 pulse width"}, pw_err, 0);
    chk(su_err == 0, {tag, " R3 setup"}, su_err, 0);
    chk(hd_err == 0, {tag, " R3 hold"}, hd_err, 0);
    chk(rail_err == 0, {tag, " R2 pulse context"}, rail_err, 0);
    chk(rd_err == 0 && cont_err == 0, {tag, " R4 read context"}, rd_err + cont_err, 0);
  endtask

  initial begin
    start = 1'b0; first_a = '0; last_a = '0; rst_n = 1'b0; prev_addr = '0;
    rd_cnt = 0;
    fresh();
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ce_n && oe_n && pgm_n, "R1 strobes high", {ce_n, oe_n, pgm_n}, 7);
    chk(!dq_oe && !vpp && !boost && !vfy, "R1 drivers and rails off", {dq_oe, vpp, boost, vfy}, 0);
    chk(!busy && !done && !fail, "R1 status low", {busy, done, fail}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // full range with mid-run start that must be ignored (R5, R8, R9)
    fresh();
    kick(0, N - 1);
    repeat (100) @(negedge clk);
    first_a = 4'd3; last_a = 4'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(done && !fail, "R9 full range success", fail, 0);
    for (int a = 0; a < N; a++) begin
      chk(mem[a] == src_mem[a], "R5 memory content", mem[a], src_mem[a]);
      chk(pcount[a] == exp_pulses(a), "R5 pulse count", pcount[a], exp_pulses(a));
    end
    chk(final_seen == 16'hFFFF, "R8 final pass coverage", final_seen, 16'hFFFF);
    timing_checks("full");
    chk(!busy && !vpp && !boost && !vfy, "R9 idle rails after success", {busy, vpp, boost, vfy}, 0);
    repeat (10) @(negedge clk);
    chk(done && !fail, "R9 done holds", done, 1);

    // single address (R10)
    fresh();
    kick(9, 9);
    wait_done();
    chk(done && !fail, "R10 single address success", fail, 0);
    chk(pcount[9] == exp_pulses(9), "R10 pulses at address", pcount[9], exp_pulses(9));
    chk(pcount[8] == 0 && pcount[10] == 0, "R10 neighbours untouched", pcount[8] + pcount[10], 0);
    chk(final_seen == 16'h0200, "R10 final read only address", final_seen, 16'h0200);

    // set-back request (R7): mem[3]=0x0F, source 0x3C needs bits 4,5 back to one
    fresh();
    mem[3] = 8'h0F; src_mem[3] = 8'h3C;
    kick(2, 5);
    wait_done();
    chk(fail && done, "R7 fail raised", fail, 1);
    chk(fail_addr == 4'd3, "R7 fail address", fail_addr, 3);
    chk(pcount[3] == 1, "R7 single pulse", pcount[3], 1);
    chk(pcount[4] == 0, "R7 later address untouched", pcount[4], 0);
    chk(pcount[2] == exp_pulses(2), "R5 earlier address", pcount[2], exp_pulses(2));
    timing_checks("setback");

    // retry exhaustion (R6)
    fresh();
    need[7] = 100;
    kick(6, 8);
    wait_done();
    chk(fail && done, "R6 fail raised", fail, 1);
    chk(fail_addr == 4'd7, "R6 fail address", fail_addr, 7);
    chk(pcount[7] == MAXP, "R6 pulse limit", pcount[7], MAXP);
    chk(pcount[8] == 0, "R6 later address untouched", pcount[8], 0);
    chk(final_seen == '0, "R8 no final pass after loop failure", final_seen, 0);
    chk(!vpp && !boost && !busy, "R6 rails off after fail", {vpp, boost, busy}, 0);
    repeat (8) @(negedge clk);
    chk(fail && fail_addr == 4'd7, "R9 failure holds", fail_addr, 7);

    // failure only visible under verify rails (R8)
    fresh();
    weak_en = 1'b1; weak_a = 4'd5;
    kick(0, N - 1);
    wait_done();
    chk(fail && done, "R8 final pass fail", fail, 1);
    chk(fail_addr == 4'd5, "R8 final fail address", fail_addr, 5);
    for (int a = 0; a < N; a++)
      chk(pcount[a] == exp_pulses(a), "R8 loop completed before final pass", pcount[a], exp_pulses(a));
    chk(final_seen == 16'h003F, "R8 final stops at failing address", final_seen, 16'h003F);

    // sweep of short ranges with rotated pulse needs (R5)
    for (int lo = 0; lo < N; lo += 5) begin
      fresh();
      for (int a = 0; a < N; a++) need[a] = ((a + lo) % MAXP) + 1;
      kick(lo, lo + 1);
      wait_done();
      chk(done && !fail, "R5 sweep success", fail, 0);
      chk(pcount[lo] == exp_pulses(lo), "R5 sweep pulses first", pcount[lo], exp_pulses(lo));
      chk(pcount[lo + 1] == exp_pulses(lo + 1), "R5 sweep pulses second", pcount[lo + 1], exp_pulses(lo + 1));
      timing_checks("sweep");
    end

    summary();
    $finish;
  end

endmodule